// File: doc/BRIEF.md
# Subroutine Call and Return Bus Sequencer

This block is a cycle-exact micro-sequencer for an 8-bit processor with a 16-bit address space. It executes three control-transfer instructions over a single-port memory bus that makes one access per clock: absolute jump, absolute subroutine call and subroutine return. It holds a program counter and an 8-bit stack pointer. The stack lives in page one (0x0100 plus the stack pointer) and grows downward.

The order of bus accesses is part of the contract. Code can place the stack over the operand bytes of a call, so the cycle in which each byte is read or written decides the jump target. A parameter selects one of two call orderings. The legacy ordering reads the target high byte after the return address has been pushed. The operand-first ordering reads both target bytes before any push. Every other opcode stops the sequencer and raises a halt flag. The block exposes the program counter, the stack pointer and an instruction-boundary strobe, so the whole bus trace can be checked against a memory model.

Top module: `callret_seq`

## Requirements
- R1: Opcode 0x4C (absolute jump) takes three cycles: it reads the opcode, then the target low byte, then the target high byte from consecutive addresses. The next opcode fetch uses that target.
- R2: With OPERAND_FIRST=0, opcode 0x20 (absolute call) takes six cycles. The bus order is: opcode read, target-low read, a dummy read at the current stack slot, return-high write, return-low write, then the target-high read.
- R3: A push writes to 0x0100 + stack pointer and then decrements the stack pointer. The two writes of a call go to consecutive descending addresses in page one, and the stack pointer ends two lower.
- R4: The value a call pushes is the address of its own last operand byte. The high byte is written first.
- R5: With OPERAND_FIRST=0, a call whose stack slots overlap its operand uses the freshly written byte as the target high byte. A call at 0x0103 to 0x1234 with the stack pointer at 0x05 continues at 0x0134.
- R6: With OPERAND_FIRST=1, the call reads both target bytes first, then makes a dummy stack read, then performs the two pushes (six cycles). The same overlapping call continues at 0x1234.
- R7: Opcode 0x60 (return) takes six cycles. The bus order is: opcode read, dummy read of the next byte, dummy read at the current stack slot while the stack pointer increments, low-byte pull, high-byte pull, then a dummy read at the pulled address. Each pull increments the stack pointer before reading, and the stack pointer ends two higher.
- R8: Return resumes fetching at the pulled address plus one.
- R9: Any opcode other than 0x4C, 0x20 or 0x60 raises halt_o from the next cycle onward. After that the sequencer makes no writes and holds the program counter and bus address.
- R10: insn_start_o is high exactly in opcode-fetch cycles. These cycles are reads at the program counter and are never back to back.
- R11: While reset is active, the bus address and the program counter equal RESET_PC, the stack pointer equals RESET_SP, write enable is low and halt_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_o | output | 16 | Memory address of this cycle's access |
| bus_rdata_i | input | 8 | Read data, valid in the same cycle |
| bus_wdata_o | output | 8 | Write data |
| bus_we_o | output | 1 | Write enable (read when low) |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack-pointer register |
| insn_start_o | output | 1 | High in opcode-fetch cycles |
| halt_o | output | 1 | Unsupported opcode seen; sequencer stopped |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that the stack pointer is at least one whenever a call pushes. A pair of pushes that wrapped from 0x0100 to 0x01FF would break the descending-address property. The stimulus runs every scenario with a stack pointer of 0x05 and a memory model whose read data is a pure function of the address. This keeps within both assumptions and still lets the stack overlap a call operand.

// File: rtl/callret_pkg.sv
package callret_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam byte_t OP_JMP  = 8'h4C;
  localparam byte_t OP_CALL = 8'h20;
  localparam byte_t OP_RET  = 8'h60;

  typedef enum logic [3:0] {
    S_FETCH,
    S_JLO, S_JHI,
    S_CLO, S_CHI_A, S_CINT, S_CPH, S_CPL, S_CHI,
    S_RDUM, S_RINC, S_RPLO, S_RPHI, S_RFIX,
    S_HALT
  } state_e;
endpackage

// File: rtl/callret_ctl.sv
module callret_ctl
  import callret_pkg::*;
#(
  parameter bit OPERAND_FIRST = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  byte_t  rdata_i,
  output state_e state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_FETCH: begin
        if (rdata_i == OP_JMP)       state_d = S_JLO;
        else if (rdata_i == OP_CALL) state_d = S_CLO;
        else if (rdata_i == OP_RET)  state_d = S_RDUM;
        else                         state_d = S_HALT;
      end
      S_JLO:   state_d = S_JHI;
      S_JHI:   state_d = S_FETCH;
      S_CLO:   state_d = OPERAND_FIRST ? S_CHI_A : S_CINT;
      S_CHI_A: state_d = S_CINT;
      S_CINT:  state_d = S_CPH;
      S_CPH:   state_d = S_CPL;
      S_CPL:   state_d = OPERAND_FIRST ? S_FETCH : S_CHI;
      S_CHI:   state_d = S_FETCH;
      S_RDUM:  state_d = S_RINC;
      S_RINC:  state_d = S_RPLO;
      S_RPLO:  state_d = S_RPHI;
      S_RPHI:  state_d = S_RFIX;
      S_RFIX:  state_d = S_FETCH;
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/callret_dp.sv
module callret_dp
  import callret_pkg::*;
#(
  parameter bit    OPERAND_FIRST = 1'b0,
  parameter addr_t RESET_PC      = 16'h0100,
  parameter byte_t RESET_SP      = 8'hFF,
  parameter byte_t STACK_PAGE    = 8'h01
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_e state_i,
  input  byte_t  rdata_i,
  output addr_t  addr_o,
  output byte_t  wdata_o,
  output logic   we_o,
  output addr_t  pc_o,
  output byte_t  sp_o
);
  addr_t pc_q;
  byte_t sp_q;   // also parks the call target low byte (legacy order)
  byte_t alu_q;  // real stack pointer travels here during a call
  byte_t lo_q;
  byte_t hi_q;

  // Operand-first ordering needs a holding register for the high byte.
  generate
    if (OPERAND_FIRST) begin : g_hi_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                hi_q <= '0;
        else if (state_i == S_CHI_A) hi_q <= rdata_i;
      end
    end else begin : g_no_hi
      assign hi_q = '0;
    end
  endgenerate

  always_comb begin
    addr_o  = pc_q;
    we_o    = 1'b0;
    wdata_o = pc_q[DATA_W-1:0];
    case (state_i)
      S_CINT: addr_o = {STACK_PAGE, alu_q};
      S_CPH: begin
        addr_o  = {STACK_PAGE, alu_q};
        we_o    = 1'b1;
        wdata_o = pc_q[ADDR_W-1:DATA_W];
      end
      S_CPL: begin
        addr_o  = {STACK_PAGE, alu_q};
        we_o    = 1'b1;
        wdata_o = pc_q[DATA_W-1:0];
      end
      S_RINC, S_RPLO, S_RPHI: addr_o = {STACK_PAGE, sp_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      sp_q  <= RESET_SP;
      alu_q <= '0;
      lo_q  <= '0;
    end else begin
      case (state_i)
        S_FETCH: pc_q <= pc_q + 1'b1;
        S_JLO: begin
          lo_q <= rdata_i;
          pc_q <= pc_q + 1'b1;
        end
        S_JHI: pc_q <= {rdata_i, lo_q};
        S_CLO: begin
          sp_q  <= rdata_i;
          alu_q <= sp_q;
          pc_q  <= pc_q + 1'b1;
        end
        S_CPH: alu_q <= alu_q - 1'b1;
        S_CPL: begin
          alu_q <= alu_q - 1'b1;
          if (OPERAND_FIRST) begin
            pc_q <= {hi_q, sp_q};
            sp_q <= alu_q - 1'b1;
          end
        end
        S_CHI: begin
          pc_q <= {rdata_i, sp_q};
          sp_q <= alu_q;
        end
        S_RINC: sp_q <= sp_q + 1'b1;
        S_RPLO: begin
          lo_q <= rdata_i;
          sp_q <= sp_q + 1'b1;
        end
        S_RPHI: pc_q <= {rdata_i, lo_q};
        S_RFIX: pc_q <= pc_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign pc_o = pc_q;
  assign sp_o = sp_q;
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter bit          OPERAND_FIRST = 1'b0,
  parameter logic [15:0] RESET_PC      = 16'h0100,
  parameter logic [7:0]  RESET_SP      = 8'hFF,
  parameter logic [7:0]  STACK_PAGE    = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] bus_addr_o,
  input  logic [7:0]  bus_rdata_i,
  output logic [7:0]  bus_wdata_o,
  output logic        bus_we_o,
  output logic [15:0] pc_o,
  output logic [7:0]  sp_o,
  output logic        insn_start_o,
  output logic        halt_o
);
  state_e state;

  callret_ctl #(.OPERAND_FIRST(OPERAND_FIRST)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rdata_i (bus_rdata_i),
    .state_o (state)
  );

  callret_dp #(
    .OPERAND_FIRST (OPERAND_FIRST),
    .RESET_PC      (RESET_PC),
    .RESET_SP      (RESET_SP),
    .STACK_PAGE    (STACK_PAGE)
  ) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .rdata_i (bus_rdata_i),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o),
    .we_o    (bus_we_o),
    .pc_o    (pc_o),
    .sp_o    (sp_o)
  );

  assign insn_start_o = (state == S_FETCH);
  assign halt_o       = (state == S_HALT);
endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] bus_addr_o,
  input logic        bus_we_o,
  input logic [15:0] pc_o,
  input logic        insn_start_o,
  input logic        halt_o
);
  // R3
  stack_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> bus_addr_o[15:8] == STACK_PAGE);

  // R2
  push_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && !$past(bus_we_o)) |=> bus_we_o);

  // R3
  push_desc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && $past(bus_we_o)) |-> bus_addr_o == $past(bus_addr_o) - 16'd1);

  // R9
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && !bus_we_o && $stable(bus_addr_o) && $stable(pc_o)));

  // R10
  insn_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_start_o |=> !insn_start_o);

  // R10
  insn_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_start_o |-> (!bus_we_o && bus_addr_o == pc_o));
endmodule

bind callret_seq callret_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_o   (bus_addr_o),
  .bus_we_o     (bus_we_o),
  .pc_o         (pc_o),
  .insn_start_o (insn_start_o),
  .halt_o       (halt_o)
);

// File: tb/callret_seq_tb.sv
`timescale 1ns/1ps
module callret_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  mem_a [4096];
  logic [7:0]  mem_b [4096];
  logic [15:0] addr_a, addr_b, pc_a, pc_b;
  logic [7:0]  wd_a, wd_b, sp_a, sp_b, rd_a, rd_b;
  logic        we_a, we_b, ins_a, ins_b, hlt_a, hlt_b;
  logic        ld_en = 1'b0, ld_clr = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign rd_a = mem_a[addr_a[11:0]];
  assign rd_b = mem_b[addr_b[11:0]];

  callret_seq #(.OPERAND_FIRST(1'b0), .RESET_PC(16'h0100), .RESET_SP(8'h05)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_o(addr_a), .bus_rdata_i(rd_a),
    .bus_wdata_o(wd_a), .bus_we_o(we_a), .pc_o(pc_a), .sp_o(sp_a),
    .insn_start_o(ins_a), .halt_o(hlt_a));

  callret_seq #(.OPERAND_FIRST(1'b1), .RESET_PC(16'h0100), .RESET_SP(8'h05)) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_o(addr_b), .bus_rdata_i(rd_b),
    .bus_wdata_o(wd_b), .bus_we_o(we_b), .pc_o(pc_b), .sp_o(sp_b),
    .insn_start_o(ins_b), .halt_o(hlt_b));

  always @(posedge clk) begin
    if (ld_clr) begin
      for (int i = 0; i < 4096; i++) begin
        mem_a[i] <= 8'h00;
        mem_b[i] <= 8'h00;
      end
    end else if (ld_en) begin
      mem_a[ld_addr] <= ld_data;
      mem_b[ld_addr] <= ld_data;
    end else begin
      if (we_a) mem_a[addr_a[11:0]] <= wd_a;
      if (we_b) mem_b[addr_b[11:0]] <= wd_b;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_a(input string req, input int ad, input int we, input int wd);
    chk(req, "legacy addr", addr_a, ad);
    chk(req, "legacy we", we_a, we);
    if (we != 0) chk(req, "legacy wdata", wd_a, wd);
  endtask

  task automatic bus_b(input string req, input int ad, input int we, input int wd);
    chk(req, "alt addr", addr_b, ad);
    chk(req, "alt we", we_b, we);
    if (we != 0) chk(req, "alt wdata", wd_b, wd);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic prep();
    rst_n = 1'b0;
    @(negedge clk) ld_clr = 1'b1;
    @(negedge clk) ld_clr = 1'b0;
  endtask

  task automatic poke(input int a, input int d);
    ld_addr = a[11:0];
    ld_data = d[7:0];
    ld_en   = 1'b1;
    @(negedge clk) ld_en = 1'b0;
  endtask

  task automatic go();
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic test_reset();
    prep();
    chk("R11", "addr", addr_a, 16'h0100);
    chk("R11", "we", we_a, 0);
    chk("R11", "pc", pc_a, 16'h0100);
    chk("R11", "sp", sp_a, 8'h05);
    chk("R11", "halt", hlt_a, 0);
    chk("R11", "alt pc", pc_b, 16'h0100);
  endtask

  // jmp 0x0103; call 0x1234 at 0x0103 with stack over the operand
  task automatic test_overlap();
    prep();
    poke(16'h100, 8'h4C); poke(16'h101, 8'h03); poke(16'h102, 8'h01);
    poke(16'h103, 8'h20); poke(16'h104, 8'h34); poke(16'h105, 8'h12);
    go();
    bus_a("R1", 16'h0100, 0, 0); bus_b("R1", 16'h0100, 0, 0);
    chk("R10", "insn at fetch", ins_a, 1);
    step(); bus_a("R1", 16'h0101, 0, 0); chk("R10", "insn mid", ins_a, 0);
    step(); bus_a("R1", 16'h0102, 0, 0);
    step(); bus_a("R1", 16'h0103, 0, 0); bus_b("R1", 16'h0103, 0, 0);
    chk("R1", "pc after jmp", pc_a, 16'h0103); chk("R10", "insn", ins_a, 1);
    step(); bus_a("R2", 16'h0104, 0, 0); bus_b("R6", 16'h0104, 0, 0);
    step(); bus_a("R2", 16'h0105, 0, 0); bus_b("R6", 16'h0105, 0, 0);
    step(); bus_a("R4", 16'h0105, 1, 8'h01); bus_b("R6", 16'h0105, 0, 0);
    step(); bus_a("R4", 16'h0104, 1, 8'h05); bus_b("R4", 16'h0105, 1, 8'h01);
    step(); bus_a("R2", 16'h0105, 0, 0); bus_b("R4", 16'h0104, 1, 8'h05);
    step();
    bus_a("R5", 16'h0134, 0, 0); chk("R5", "legacy pc", pc_a, 16'h0134);
    chk("R3", "legacy sp", sp_a, 8'h03); chk("R10", "insn", ins_a, 1);
    bus_b("R6", 16'h1234, 0, 0); chk("R6", "alt pc", pc_b, 16'h1234);
    chk("R3", "alt sp", sp_b, 8'h03);
    chk("R4", "stack hi", mem_a[12'h105], 8'h01);
    chk("R4", "stack lo", mem_a[12'h104], 8'h05);
    step(); chk("R9", "legacy halt", hlt_a, 1); chk("R9", "alt halt", hlt_b, 1);
  endtask

  // jmp 0x0200; call 0x0300; return at 0x0300
  task automatic test_call_ret();
    prep();
    poke(16'h100, 8'h4C); poke(16'h101, 8'h00); poke(16'h102, 8'h02);
    poke(16'h200, 8'h20); poke(16'h201, 8'h00); poke(16'h202, 8'h03);
    poke(16'h300, 8'h60);
    go();
    step(); step(); step();
    bus_a("R1", 16'h0200, 0, 0); bus_b("R1", 16'h0200, 0, 0);
    step(); bus_a("R2", 16'h0201, 0, 0); bus_b("R6", 16'h0201, 0, 0);
    step(); bus_a("R2", 16'h0105, 0, 0); bus_b("R6", 16'h0202, 0, 0);
    step(); bus_a("R3", 16'h0105, 1, 8'h02); bus_b("R6", 16'h0105, 0, 0);
    step(); bus_a("R3", 16'h0104, 1, 8'h02); bus_b("R3", 16'h0105, 1, 8'h02);
    step(); bus_a("R2", 16'h0202, 0, 0); bus_b("R3", 16'h0104, 1, 8'h02);
    step(); bus_a("R2", 16'h0300, 0, 0); bus_b("R6", 16'h0300, 0, 0);
    chk("R3", "sp after call", sp_a, 8'h03); chk("R3", "alt sp after call", sp_b, 8'h03);
    step(); bus_a("R7", 16'h0301, 0, 0); bus_b("R7", 16'h0301, 0, 0);
    step(); bus_a("R7", 16'h0103, 0, 0);
    step(); bus_a("R7", 16'h0104, 0, 0); chk("R7", "sp at low pull", sp_a, 8'h04);
    step(); bus_a("R7", 16'h0105, 0, 0); bus_b("R7", 16'h0105, 0, 0);
    step(); bus_a("R7", 16'h0202, 0, 0);
    step();
    bus_a("R8", 16'h0203, 0, 0); chk("R8", "pc after ret", pc_a, 16'h0203);
    chk("R8", "alt pc after ret", pc_b, 16'h0203);
    chk("R7", "sp after ret", sp_a, 8'h05); chk("R10", "insn", ins_a, 1);
    step(); chk("R9", "halt after zero opcode", hlt_a, 1);
  endtask

  task automatic test_halt();
    prep();
    poke(16'h100, 8'hEA);
    go();
    chk("R9", "halt before decode", hlt_a, 0);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R9", "halt", hlt_a, 1);
      bus_a("R9", 16'h0101, 0, 0);
      chk("R9", "pc held", pc_a, 16'h0101);
      chk("R10", "no fetch in halt", ins_a, 0);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    test_reset();
    test_overlap();
    test_call_ret();
    test_halt();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule